// File: doc/BRIEF.md
# Partial-Decode Memory and Port Selector

This block sits between the address and data buses of a small 8-bit controller with a 16-bit address space. It splits the address space in two with the top address bit. The lower half selects program memory. The upper half selects one of four I/O slots. Only the top bit and the two lowest address bits take part in the decode, so the decode logic stays very shallow. The cost is that the four slots repeat every four bytes across the whole upper half.

Slots 0 and 1 are byte-wide output registers, loaded from the write data bus. Slots 2 and 3 pass two external input ports through to the read data path. A read of an output slot returns the value held in its register. Chip selects are qualified by an access strobe (read or write), so no select is active while the bus is idle.

Top module: `mmio_lite_decoder`

## Requirements
- R1: `mem_cs` is 1 exactly when `rd_en` or `wr_en` is high and address bit 15 is 0; address bits 14..0 do not affect it.
- R2: When `rd_en` or `wr_en` is high and address bit 15 is 1, exactly one bit of `io_cs` is high, at index `addr[1:0]`; otherwise `io_cs` is 0.
- R3: `mem_cs` and any bit of `io_cs` are never high in the same cycle.
- R4: A cycle with `wr_en` high, address bit 15 at 1 and `addr[1:0]` equal to 0 (or 1) loads `wdata` into output port 0 (or 1) at that clock edge. The new value appears on `out_ports[7:0]` (or `out_ports[15:8]`) in the following cycle.
- R5: Output ports keep their value after any cycle that is not such a write. This covers writes to slots 2 and 3, writes in the memory half, and reads.
- R6: An active-low `rst_n` clears both output ports to 0.
- R7: When `rd_en` is high, address bit 15 is 1 and `addr[1:0]` is 2 (or 3), `rdata` equals `in_ports[7:0]` (or `in_ports[15:8]`) in the same cycle.
- R8: When `rd_en` is high, address bit 15 is 1 and `addr[1:0]` is 0 (or 1), `rdata` equals the current contents of output port 0 (or 1).
- R9: `rdata` is 0 whenever `rd_en` is low or address bit 15 is 0.
- R10: Address bits 14..2 are ignored. Any two upper-half addresses that share `addr[1:0]` select, read and write the same slot. For example, 8001h and FFFDh both reach output port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| in_ports | input | 16 | Input port 0 in bits 7:0, input port 1 in bits 15:8 |
| mem_cs | output | 1 | Program memory select |
| io_cs | output | 4 | One-hot I/O slot select |
| rdata | output | 8 | Read data from the selected slot, zero otherwise |
| out_ports | output | 16 | Output port 0 in bits 7:0, output port 1 in bits 15:8 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, two slot-select bits, and two output plus two input ports. With these values every slot is reachable. Random upper-half addresses reach the full alias range from 8000h to FFFFh, including both ends. The memory half sees addresses that differ from I/O addresses only in bit 15. A reset is also applied in the middle of the run, after both output ports have been loaded.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    typedef enum logic [0:0] {
        RGN_MEM = 1'b0,
        RGN_IO  = 1'b1
    } region_e;

    function automatic region_e region_of(input logic msb);
        return msb ? RGN_IO : RGN_MEM;
    endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode #(
    parameter int ADDR_W   = 16,
    parameter int SEL_BITS = 2
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       access,
    output logic                       mem_cs,
    output logic [(1<<SEL_BITS)-1:0]   io_cs
);
    import mmio_dec_pkg::*;

    localparam int NUM_IO = 1 << SEL_BITS;

    region_e             rgn;
    logic [SEL_BITS-1:0] slot;

    assign rgn    = region_of(addr[ADDR_W-1]);
    assign slot   = addr[SEL_BITS-1:0];
    assign mem_cs = access && (rgn == RGN_MEM);

    for (genvar g = 0; g < NUM_IO; g++) begin : g_slot
        assign io_cs[g] = access && (rgn == RGN_IO) && (slot == SEL_BITS'(g));
    end

endmodule

// File: rtl/mmio_out_regs.sv
module mmio_out_regs #(
    parameter int DATA_W  = 8,
    parameter int NUM_OUT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_OUT-1:0]          wr_sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NUM_OUT*DATA_W-1:0]   port_flat
);

    typedef struct packed {
        logic [NUM_OUT-1:0][DATA_W-1:0] port;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_OUT; k++) begin
            if (wr_sel[k]) begin
                st_d.port[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_flat = st_q.port;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
        // R4
        load_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel[g] |=> port_flat[g*DATA_W +: DATA_W] == $past(wdata));
        // R5
        hold_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel[g] |=> $stable(port_flat[g*DATA_W +: DATA_W]));
    end

endmodule

// File: rtl/mmio_read_mux.sv
module mmio_read_mux #(
    parameter int DATA_W   = 8,
    parameter int NUM_OUT  = 2,
    parameter int NUM_IN   = 2,
    parameter int SEL_BITS = 2
) (
    input  logic                       rd_hit,
    input  logic [SEL_BITS-1:0]        slot,
    input  logic [NUM_OUT*DATA_W-1:0]  out_flat,
    input  logic [NUM_IN*DATA_W-1:0]   in_flat,
    output logic [DATA_W-1:0]          rdata
);
    localparam int NUM_IO = 1 << SEL_BITS;

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            for (int k = 0; k < NUM_IO; k++) begin
                if (int'(slot) == k) begin
                    if (k < NUM_OUT) begin
                        rdata = out_flat[k*DATA_W +: DATA_W];
                    end else if (k < NUM_OUT + NUM_IN) begin
                        rdata = in_flat[(k-NUM_OUT)*DATA_W +: DATA_W];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mmio_lite_decoder.sv
module mmio_lite_decoder #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int SEL_BITS = 2,
    parameter int NUM_OUT  = 2,
    parameter int NUM_IN   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [NUM_IN*DATA_W-1:0]     in_ports,
    output logic                         mem_cs,
    output logic [(1<<SEL_BITS)-1:0]     io_cs,
    output logic [DATA_W-1:0]            rdata,
    output logic [NUM_OUT*DATA_W-1:0]    out_ports
);
    localparam int NUM_IO = 1 << SEL_BITS;

    logic               access;
    logic               rd_hit;
    logic [NUM_OUT-1:0] wr_sel;

    assign access = rd_en || wr_en;
    assign rd_hit = rd_en && addr[ADDR_W-1];
    assign wr_sel = io_cs[NUM_OUT-1:0] & {NUM_OUT{wr_en}};

    mmio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .SEL_BITS (SEL_BITS)
    ) u_dec (
        .addr   (addr),
        .access (access),
        .mem_cs (mem_cs),
        .io_cs  (io_cs)
    );

    mmio_out_regs #(
        .DATA_W  (DATA_W),
        .NUM_OUT (NUM_OUT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .wdata     (wdata),
        .port_flat (out_ports)
    );

    mmio_read_mux #(
        .DATA_W   (DATA_W),
        .NUM_OUT  (NUM_OUT),
        .NUM_IN   (NUM_IN),
        .SEL_BITS (SEL_BITS)
    ) u_rmux (
        .rd_hit   (rd_hit),
        .slot     (addr[SEL_BITS-1:0]),
        .out_flat (out_ports),
        .in_flat  (in_ports),
        .rdata    (rdata)
    );

    // R3
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_cs && (|io_cs)));

    // R2
    io_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(io_cs));

    // R7
    in_port_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1] && int'(addr[SEL_BITS-1:0]) == NUM_OUT)
        |-> rdata == in_ports[DATA_W-1:0]);

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || !addr[ADDR_W-1]) |-> rdata == '0);

    // R1
    mem_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !addr[ADDR_W-1]) |-> (mem_cs && io_cs == '0));

endmodule

// File: tb/tb_mmio_lite_decoder.sv
module tb_mmio_lite_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] in_ports = '0;
    logic        mem_cs;
    logic [3:0]  io_cs;
    logic [7:0]  rdata;
    logic [15:0] out_ports;

    int compared = 0;
    int mismatched = 0;
    int m_out[2];
    bit last_loaded = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_lite_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .in_ports(in_ports),
        .mem_cs(mem_cs), .io_cs(io_cs), .rdata(rdata), .out_ports(out_ports)
    );

    task automatic cmp(input string req, input string ctx, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
        end
    endtask

    task automatic step(input string ctx, input logic [15:0] a, input logic [7:0] d,
                        input logic w, input logic r, input logic [15:0] inp);
        int idx;
        int e_mem, e_io, e_rd, e_out;
        @(negedge clk);
        addr = a; wdata = d; wr_en = w; rd_en = r; in_ports = inp;
        #1;
        idx   = int'(a[1:0]);
        e_mem = ((w || r) && !a[15]) ? 1 : 0;
        e_io  = ((w || r) && a[15]) ? (1 << idx) : 0;
        if (!r || !a[15])  e_rd = 0;
        else if (idx < 2)  e_rd = m_out[idx];
        else if (idx == 2) e_rd = int'(inp[7:0]);
        else               e_rd = int'(inp[15:8]);
        e_out = (m_out[1] << 8) | m_out[0];
        cmp("R1", ctx, int'(mem_cs), e_mem);
        cmp("R2", ctx, int'(io_cs), e_io);
        cmp("R3", ctx, int'(mem_cs && (io_cs != 0)), 0);
        if (!r || !a[15])  cmp("R9", ctx, int'(rdata), e_rd);
        else if (idx < 2)  cmp("R8", ctx, int'(rdata), e_rd);
        else               cmp("R7", ctx, int'(rdata), e_rd);
        if (last_loaded) cmp("R4", ctx, int'(out_ports), e_out);
        else             cmp("R5", ctx, int'(out_ports), e_out);
        @(posedge clk);
        last_loaded = 0;
        if (w && a[15] && idx < 2) begin
            m_out[idx] = int'(d);
            last_loaded = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        m_out[0] = 0; m_out[1] = 0;
        last_loaded = 0;
        @(negedge clk);
        #1;
        cmp("R6", "reset", int'(out_ports), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        m_out[0] = 0; m_out[1] = 0;
        repeat (3) @(posedge clk);
        do_reset();
        step("idle", 16'h0000, 8'h00, 0, 0, 16'h0000);
        step("R1 mem read low", 16'h0000, 8'h00, 0, 1, 16'hA55A);
        step("R1 mem write top", 16'h7FFF, 8'h3C, 1, 0, 16'hA55A);
        step("R5 mem write looks like slot0", 16'h7FFC, 8'hEE, 1, 0, 16'h1234);
        step("R4 write port0", 16'h8000, 8'h5A, 1, 0, 16'h1234);
        step("R4 write port1", 16'h8001, 8'hC3, 1, 0, 16'h1234);
        step("R8 read port0", 16'h8000, 8'h00, 0, 1, 16'h1234);
        step("R8 read port1", 16'h8001, 8'h00, 0, 1, 16'h1234);
        step("R7 read in0", 16'h8002, 8'h00, 0, 1, 16'hBE34);
        step("R7 read in1", 16'h8003, 8'h00, 0, 1, 16'hBE34);
        step("R5 write in0 slot", 16'h8002, 8'h77, 1, 0, 16'hBE34);
        step("R5 write in1 slot", 16'h8003, 8'h88, 1, 0, 16'hBE34);
        step("R9 read mem half", 16'h0002, 8'h00, 0, 1, 16'hBE34);
        step("R10 alias write FFFD", 16'hFFFD, 8'h91, 1, 0, 16'h0F0F);
        step("R10 alias read 8001", 16'h8001, 8'h00, 0, 1, 16'h0F0F);
        step("R10 alias write FFFC", 16'hFFFC, 8'h42, 1, 0, 16'h0F0F);
        step("R10 alias read ABC0", 16'hABC0, 8'h00, 0, 1, 16'h0F0F);
        step("R10 alias read FFFE", 16'hFFFE, 8'h00, 0, 1, 16'h6655);
        step("R10 alias read 8007", 16'h8007, 8'h00, 0, 1, 16'h6655);
        step("rd and wr together", 16'h9000, 8'h19, 1, 1, 16'h6655);
        step("after rd+wr", 16'h9000, 8'h00, 0, 1, 16'h6655);
        step("R9 idle upper", 16'hFFFF, 8'hFF, 0, 0, 16'hFFFF);
        do_reset();
        step("R6 read after reset", 16'h8000, 8'h00, 0, 1, 16'h0000);
        step("R6 read port1 after reset", 16'h8001, 8'h00, 0, 1, 16'h0000);
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step("random", rv[15:0], rv[23:16], rv[24], rv[25], {rv[31:24], rv[7:0]});
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule